// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block keeps wall-clock time for a chip that also has an always-on, low-power region. A 47-bit counter advances once per low-power tick. Its upper 32 bits are whole seconds and its lower 15 bits are the fraction of a second. A 47-bit alarm value is compared against the counter. Control, status, interrupt-enable and general-purpose registers sit beside them on a 32-bit bus. One interrupt output is raised when any enabled status flag is set.

Writes from the bus do not land at once. Each write to a low-power register is held in a single-entry holding stage and is applied only after the next low-power tick. Software learns that the write has landed from a done flag, and reading the status register clears that flag. The interrupt-enable register is the only exception: it is written at bus speed.

The low-power domain is represented by `lp_tick`, a one-cycle strobe already in the bus clock domain.

The write path is a three-state machine:
- `WS_IDLE` goes to `WS_WAIT_TICK` when a write is accepted.
- `WS_WAIT_TICK` goes to `WS_LAND` when `lp_tick` is sampled high.
- `WS_LAND` always returns to `WS_IDLE`. The held write is applied on the cycle the machine leaves `WS_LAND`.

Top module: `secure_rtc`

## Requirements
- R1: After reset, status (offset 0x14) reads 0x0000_0203: ready bit 9, not-valid bit 1 and violation bit 0 are set. The seconds word (0x00) reads 0, the alarm seconds word (0x08) reads 0xFFFF_FFFF, and `irq` is low.
- R2: A bus write to any offset other than 0x18 behaves as follows:
  - Busy (status bit 10) is set and ready (bit 9) is clear from the cycle after the write until the write lands.
  - The write lands on the second clock edge after the first `lp_tick` that follows it.
  - Landing sets done (bit 8) and clears busy.
- R3: A status read returns the flags as they were before the read edge and then clears done. If a write lands on the same edge as the read, done stays set.
- R4: A write to the interrupt-enable register (0x18) works as follows:
  - It keeps only bits 9, 8, 7, 4 and 0.
  - It takes effect on the next edge, even while another write is busy.
  - It never sets done or error (bit 7).
- R5: A write to a low-power register issued while busy is dropped, leaving its target unchanged, and sets error (status bit 7).
- R6: A write to an offset outside {0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x3C} goes through the holding stage. When it lands it sets error instead of done.
- R7: Status bits 7, 4, 1 and 0 are cleared by writing 1 to them. Each clears only when that write lands; a 0 leaves the flag unchanged. Bits 1 and 0 never set again after reset.
- R8: The counter `{seconds, fraction}` advances by one on each `lp_tick` when control bit 3 is set and the seconds word has been written since reset. The fraction carries into the seconds.
- R9: The counter holds when control bit 3 is clear or the seconds word has never been written. A write landing on the counter takes priority over a step on the same edge.
- R10: The alarm flag (status bit 4) is set when the counter steps onto `{alarm seconds, alarm fraction}`. Loading an alarm value equal to the current count does not set it.
- R11: `irq` is high exactly when some status bit among 9, 8, 7, 4 and 0 is set and its interrupt-enable bit is set.
- R12: Read behaviour:
  - `bus_rdata` shows the selected register on the edge after `bus_rd` and holds its value otherwise.
  - The fraction words read as 15 bits, zero-extended.
  - Control reads back only bit 3.
  - Offset 0x3C stores 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| lp_tick | input | 1 | One-cycle strobe of the low-power time base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due on the edge after `bus_rd`, so the scoreboard pops one expected word on the falling edge after each read is sampled.

A low-power write lands on the edge after the first `lp_tick` edge that follows it. The bench therefore issues reads right after a tick to catch the landing edge itself, which covers the read/landing race, and one cycle later to see the landed value. A counter step and an alarm flag are visible on the edge that samples the tick.

An interrupt-enable change and the resulting `irq` are visible one edge after the write, and `irq` is sampled on the following falling edge.

// File: rtl/secure_rtc_pkg.sv
package secure_rtc_pkg;

    localparam int OFS_SEC   = 'h00;
    localparam int OFS_FRAC  = 'h04;
    localparam int OFS_ASEC  = 'h08;
    localparam int OFS_AFRAC = 'h0C;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_STAT  = 'h14;
    localparam int OFS_IEN   = 'h18;
    localparam int OFS_GP    = 'h3C;

    localparam int BIT_BUSY = 10;
    localparam int BIT_NEXT = 9;
    localparam int BIT_DONE = 8;
    localparam int BIT_ERR  = 7;
    localparam int BIT_ALRM = 4;
    localparam int BIT_NVAL = 1;
    localparam int BIT_SVIO = 0;
    localparam int BIT_RUN  = 3;

    localparam logic [31:0] IEN_MASK = 32'h0000_0391;
    localparam logic [31:0] W1C_MASK = 32'h0000_0093;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_WAIT_TICK,
        WS_LAND
    } wsync_state_t;

    function automatic logic is_mapped(input logic [7:0] a);
        return (a == 8'(OFS_SEC))  || (a == 8'(OFS_FRAC)) ||
               (a == 8'(OFS_ASEC)) || (a == 8'(OFS_AFRAC)) ||
               (a == 8'(OFS_CTRL)) || (a == 8'(OFS_STAT)) ||
               (a == 8'(OFS_GP));
    endfunction

endpackage

// File: rtl/rtc_wr_sync.sv
module rtc_wr_sync
    import secure_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              collide,
    output logic              land_valid,
    output logic [ADDR_W-1:0] land_addr,
    output logic [DATA_W-1:0] land_data
);

    wsync_state_t state_q, state_d;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else if (req_valid && state_q == WS_IDLE) begin
            hold_addr_q <= req_addr;
            hold_data_q <= req_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:      if (req_valid) state_d = WS_WAIT_TICK;
            WS_WAIT_TICK: if (lp_tick)   state_d = WS_LAND;
            WS_LAND:                     state_d = WS_IDLE;
            default:                     state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        land_valid = 1'b0;
        unique case (state_q)
            WS_IDLE:      busy = 1'b0;
            WS_WAIT_TICK: busy = 1'b1;
            WS_LAND: begin
                busy       = 1'b1;
                land_valid = 1'b1;
            end
            default:      busy = 1'b0;
        endcase
        collide   = req_valid && busy;
        land_addr = hold_addr_q;
        land_data = hold_data_q;
    end

    assert_land_follows_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        land_valid |-> $past(lp_tick));
    assert_busy_until_land_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !land_valid) |=> busy);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import secure_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick,
    input  logic              land_valid,
    input  logic [ADDR_W-1:0] land_addr,
    input  logic [DATA_W-1:0] land_data,
    output logic [SEC_W-1:0]  cnt_sec,
    output logic [FRAC_W-1:0] cnt_frac,
    output logic [SEC_W-1:0]  alm_sec,
    output logic [FRAC_W-1:0] alm_frac,
    output logic              run_en,
    output logic [DATA_W-1:0] gp_word,
    output logic              alarm_hit
);

    localparam int CNT_W = SEC_W + FRAC_W;

    logic [CNT_W-1:0]  cnt_q, alm_q, cnt_inc;
    logic              run_q, seen_q;
    logic [DATA_W-1:0] gp_q;
    logic              land_time, step;

    assign land_time = land_valid &&
                       (land_addr == ADDR_W'(OFS_SEC) || land_addr == ADDR_W'(OFS_FRAC));
    assign step      = lp_tick && run_q && seen_q && !land_time;
    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign alarm_hit = step && (cnt_inc == alm_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            alm_q  <= {{SEC_W{1'b1}}, {FRAC_W{1'b0}}};
            run_q  <= 1'b0;
            seen_q <= 1'b0;
            gp_q   <= '0;
        end else begin
            if (land_time) begin
                if (land_addr == ADDR_W'(OFS_SEC)) begin
                    cnt_q[CNT_W-1:FRAC_W] <= land_data[SEC_W-1:0];
                    seen_q                <= 1'b1;
                end else begin
                    cnt_q[FRAC_W-1:0] <= land_data[FRAC_W-1:0];
                end
            end else if (step) begin
                cnt_q <= cnt_inc;
            end
            if (land_valid) begin
                if (land_addr == ADDR_W'(OFS_ASEC))  alm_q[CNT_W-1:FRAC_W] <= land_data[SEC_W-1:0];
                if (land_addr == ADDR_W'(OFS_AFRAC)) alm_q[FRAC_W-1:0]     <= land_data[FRAC_W-1:0];
                if (land_addr == ADDR_W'(OFS_CTRL))  run_q                 <= land_data[BIT_RUN];
                if (land_addr == ADDR_W'(OFS_GP))    gp_q                  <= land_data;
            end
        end
    end

    assign cnt_sec  = cnt_q[CNT_W-1:FRAC_W];
    assign cnt_frac = cnt_q[FRAC_W-1:0];
    assign alm_sec  = alm_q[CNT_W-1:FRAC_W];
    assign alm_frac = alm_q[FRAC_W-1:0];
    assign run_en   = run_q;
    assign gp_word  = gp_q;

    assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run_q || !seen_q) && !land_valid) |=> $stable(cnt_q));
    assert_step_by_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_tick && run_q && seen_q && !land_valid) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_alarm_on_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit && !land_valid) |=> cnt_q == alm_q);

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
    import secure_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we,
    input  logic [DATA_W-1:0] ien_wdata,
    input  logic              stat_rd,
    input  logic              land_valid,
    input  logic [ADDR_W-1:0] land_addr,
    input  logic [DATA_W-1:0] land_data,
    input  logic              collide,
    input  logic              alarm_hit,
    input  logic              busy,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] ien,
    output logic              irq
);

    logic done_q, err_q, alrm_q, nval_q, svio_q;
    logic [DATA_W-1:0] ien_q, clr;
    logic land_stat, land_ok, land_bad;

    assign land_stat = land_valid && (land_addr == ADDR_W'(OFS_STAT));
    assign land_ok   = land_valid && is_mapped(8'(land_addr));
    assign land_bad  = land_valid && !is_mapped(8'(land_addr));
    assign clr       = land_stat ? (land_data & DATA_W'(W1C_MASK)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            alrm_q <= 1'b0;
            nval_q <= 1'b1;
            svio_q <= 1'b1;
            ien_q  <= '0;
        end else begin
            if (land_ok)      done_q <= 1'b1;
            else if (stat_rd) done_q <= 1'b0;
            if (collide || land_bad) err_q <= 1'b1;
            else if (clr[BIT_ERR])   err_q <= 1'b0;
            if (alarm_hit)           alrm_q <= 1'b1;
            else if (clr[BIT_ALRM])  alrm_q <= 1'b0;
            if (clr[BIT_NVAL]) nval_q <= 1'b0;
            if (clr[BIT_SVIO]) svio_q <= 1'b0;
            if (ien_we) ien_q <= ien_wdata & DATA_W'(IEN_MASK);
        end
    end

    always_comb begin
        status           = '0;
        status[BIT_BUSY] = busy;
        status[BIT_NEXT] = !busy;
        status[BIT_DONE] = done_q;
        status[BIT_ERR]  = err_q;
        status[BIT_ALRM] = alrm_q;
        status[BIT_NVAL] = nval_q;
        status[BIT_SVIO] = svio_q;
    end

    assign ien = ien_q;
    assign irq = |(status & ien_q);

    assert_done_needs_landing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(land_valid));
    assert_read_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !land_valid) |=> !done_q);
    assert_err_after_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> err_q);
    assert_no_revalidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(nval_q) && !$rose(svio_q));

endmodule

// File: rtl/secure_rtc.sv
module secure_rtc
    import secure_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              is_ien, ien_we, req_valid, stat_rd;
    logic              busy, collide, land_valid, run_en, alarm_hit;
    logic [ADDR_W-1:0] land_addr;
    logic [DATA_W-1:0] land_data, status, ien, gp_word;
    logic [SEC_W-1:0]  cnt_sec, alm_sec;
    logic [FRAC_W-1:0] cnt_frac, alm_frac;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    assign is_ien    = (bus_addr == ADDR_W'(OFS_IEN));
    assign ien_we    = bus_wr && is_ien;
    assign req_valid = bus_wr && !is_ien;
    assign stat_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    rtc_wr_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick),
        .req_valid(req_valid), .req_addr(bus_addr), .req_data(bus_wdata),
        .busy(busy), .collide(collide),
        .land_valid(land_valid), .land_addr(land_addr), .land_data(land_data)
    );

    rtc_time_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_time (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick),
        .land_valid(land_valid), .land_addr(land_addr), .land_data(land_data),
        .cnt_sec(cnt_sec), .cnt_frac(cnt_frac), .alm_sec(alm_sec), .alm_frac(alm_frac),
        .run_en(run_en), .gp_word(gp_word), .alarm_hit(alarm_hit)
    );

    rtc_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ien_we(ien_we), .ien_wdata(bus_wdata), .stat_rd(stat_rd),
        .land_valid(land_valid), .land_addr(land_addr), .land_data(land_data),
        .collide(collide), .alarm_hit(alarm_hit), .busy(busy),
        .status(status), .ien(ien), .irq(irq)
    );

    always_comb begin
        rd_mux = '0;
        if      (bus_addr == ADDR_W'(OFS_SEC))   rd_mux = DATA_W'(cnt_sec);
        else if (bus_addr == ADDR_W'(OFS_FRAC))  rd_mux = DATA_W'(cnt_frac);
        else if (bus_addr == ADDR_W'(OFS_ASEC))  rd_mux = DATA_W'(alm_sec);
        else if (bus_addr == ADDR_W'(OFS_AFRAC)) rd_mux = DATA_W'(alm_frac);
        else if (bus_addr == ADDR_W'(OFS_CTRL))  rd_mux[BIT_RUN] = run_en;
        else if (bus_addr == ADDR_W'(OFS_STAT))  rd_mux = status;
        else if (bus_addr == ADDR_W'(OFS_IEN))   rd_mux = ien;
        else if (bus_addr == ADDR_W'(OFS_GP))    rd_mux = gp_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/secure_rtc_tb.sv
`timescale 1ns/1ps
module secure_rtc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    secure_rtc u_dut (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops one expected word per sampled read
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        lp_tick = 1'b1;
        @(negedge clk);
        lp_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic land();
        tick();
        idle(1);
    endtask

    task automatic check_irq(input logic e, input string t);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(8'h14, 32'h0000_0203, "R1");
        rd(8'h00, 32'h0, "R1");
        rd(8'h08, 32'hFFFF_FFFF, "R1");
        check_irq(1'b0, "R1");

        // R2 handshake timing, R3 read/landing race
        wr(8'h3C, 32'hA5A5_1234);
        rd(8'h14, 32'h0000_0403, "R2");
        tick();
        rd(8'h14, 32'h0000_0403, "R3");
        rd(8'h14, 32'h0000_0303, "R3");
        rd(8'h14, 32'h0000_0203, "R3");
        rd(8'h3C, 32'hA5A5_1234, "R12");

        // R4 interrupt enable at bus speed
        wr(8'h18, 32'h0000_0110);
        rd(8'h18, 32'h0000_0110, "R4");
        rd(8'h14, 32'h0000_0203, "R4");
        wr(8'h3C, 32'h1);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0000_0391, "R4");
        rd(8'h14, 32'h0000_0403, "R4");
        land();
        rd(8'h14, 32'h0000_0303, "R4");
        check_irq(1'b1, "R11");
        wr(8'h18, 32'h0);
        check_irq(1'b0, "R11");
        wr(8'h18, 32'h1);
        check_irq(1'b1, "R11");

        // R7 write-one-to-clear validity flags
        wr(8'h14, 32'h2); land();
        rd(8'h14, 32'h0000_0301, "R7");
        check_irq(1'b1, "R11");
        wr(8'h14, 32'h1); land();
        rd(8'h14, 32'h0000_0300, "R7");
        check_irq(1'b0, "R11");

        // R5 collision while busy
        wr(8'h3C, 32'h11);
        wr(8'h3C, 32'h22);
        rd(8'h14, 32'h0000_0480, "R5");
        land();
        rd(8'h3C, 32'h11, "R5");
        rd(8'h14, 32'h0000_0380, "R5");
        wr(8'h14, 32'h80);
        rd(8'h14, 32'h0000_0480, "R7");
        land();
        rd(8'h14, 32'h0000_0300, "R7");

        // R6 unmapped offset
        wr(8'h20, 32'hDEAD); land();
        rd(8'h14, 32'h0000_0280, "R6");
        wr(8'h14, 32'h80); land();
        rd(8'h14, 32'h0000_0300, "R6");

        // R9 no count before seconds written
        wr(8'h10, 32'h8); land();
        tick(); tick();
        rd(8'h04, 32'h0, "R9");
        rd(8'h00, 32'h0, "R9");
        rd(8'h10, 32'h8, "R12");

        // R8 counting with carry
        wr(8'h04, 32'hFFFF_7FFE); land();
        wr(8'h00, 32'h5); land();
        rd(8'h04, 32'h7FFE, "R12");
        rd(8'h00, 32'h5, "R8");
        tick();
        rd(8'h04, 32'h7FFF, "R8");
        tick();
        rd(8'h00, 32'h6, "R8");
        rd(8'h04, 32'h0, "R8");

        // R9 stop with enable clear
        wr(8'h10, 32'h0); land();
        tick(); tick();
        rd(8'h04, 32'h1, "R9");
        wr(8'h10, 32'h8); land();
        rd(8'h04, 32'h1, "R9");

        // R10 alarm
        wr(8'h0C, 32'h3); land();
        wr(8'h08, 32'h6); land();
        rd(8'h14, 32'h0000_0300, "R10");
        wr(8'h0C, 32'h5); land();
        tick();
        rd(8'h14, 32'h0000_0310, "R10");
        rd(8'h08, 32'h6, "R12");
        rd(8'h0C, 32'h5, "R12");
        wr(8'h18, 32'h10);
        check_irq(1'b1, "R11");
        wr(8'h14, 32'h10); land();
        rd(8'h14, 32'h0000_0300, "R7");
        check_irq(1'b0, "R11");

        idle(2);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R12: pending reads actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule